// File: doc/BRIEF.md
# Compressed Push/Pop Micro-Op Sequencer

This block takes a 16-bit compressed stack-frame instruction (push, push with frame pointer, pop, pop-and-return, pop-return-with-zero) and turns it into a timed series of micro-operations for a 32-bit core. It issues one load or store request per cycle, each with its address, register index and direction. It then issues the register writebacks for the frame pointer, a0 and the stack pointer, and for the return forms a jump to the restored return address.

Saved registers are laid out so that ra and s0 sit nearest the incoming stack pointer, as the frame-pointer convention expects. Load data returning from memory is written to the register named in the load request by the surrounding pipeline. This block writes only sp, fp (x8) and a0 (x10), through a single write port.

An instruction is taken when `instr_valid_i` is high and the block is idle. The instruction and the stack pointer are captured at that edge. Inputs are then ignored until the sequence ends.

Top module: `stack_frame_seq`

## Requirements
- R1: A word is recognised only when bits[15:13]=101 and bits[1:0]=10. Bits[12:8] select the operation: 11000 push, 11001 push with frame pointer, 11010 pop, 11100 pop-return-zero, 11110 pop-return.
- R2: Bits[7:4] are the list code. Code c in 4..14 saves c−3 registers, and code 15 saves 13. The transfer order is ra=x1, s0=x8, s1=x9, then s2..s11=x18..x27.
- R3: The frame adjustment is base + bits[3:2]×16. The base is 16 for codes 4–7, 32 for codes 8–11, 48 for codes 12–14 and 64 for code 15.
- R4: A push issues transfer k in cycle k+1 after acceptance. Each transfer is a store (`mem_we_o`=1) to sp−4(k+1), with one request per cycle.
- R5: A pop form issues transfer k in cycle k+1 as a load (`mem_we_o`=0) from sp+adj−4(k+1), using the same register order as a push.
- R6: In the final cycle, sp (x2) is written with sp−adj for a push or sp+adj for a pop. This write comes after every transfer and in the same cycle as `done_o`.
- R7: Push with frame pointer writes x8 with the captured sp in the cycle after the last store, before the sp write.
- R8: Pop-return-zero writes x10 with 0 in the cycle after the last load. Both return forms raise `jump_o` in the done cycle, and no other form does.
- R9: An unrecognised word, a reserved operation, or a list code of 0–3 raises `done_o` and `illegal_o` together in the cycle after acceptance. No memory request and no register write are issued.
- R10: `busy_o` is high from the cycle after acceptance through the done cycle. `done_o` lasts one cycle, and `instr_valid_i`, `instr_i` and `sp_i` are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction strobe |
| instr_i | input | 16 | Compressed instruction word |
| sp_i | input | 32 | Current stack pointer |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| illegal_o | output | 1 | Instruction rejected (with done) |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 store, 0 load |
| mem_addr_o | output | 32 | Transfer address |
| mem_reg_o | output | 5 | Register stored or loaded |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 5 | Register write index |
| rf_wdata_o | output | 32 | Register write data |
| jump_o | output | 1 | Jump to restored ra |

## Verification
Counting from the accepting edge, transfer k is due in cycle k+1. For a frame-pointer push or a pop-return-zero, the fp or a0 write is due in cycle n+1, and the sp write with `done_o` comes after it. For every other legal form, the sp write with `done_o` is due in cycle n+1. A rejected word gives `done_o` and `illegal_o` in cycle 1. The bench drives inputs on the falling edge. It then samples once per falling edge, compares each cycle against the slot the model predicts for that cycle, and checks idle outputs one cycle after done. While the sequence runs, it drives random words with the strobe held high to show they are ignored.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  localparam int REG_W  = 5;
  localparam int CNT_W  = 4;
  localparam int CODE_W = 4;

  typedef enum logic [2:0] {
    OP_PUSH, OP_PUSHFP, OP_POP, OP_POPRETZ, OP_POPRET
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [CODE_W-1:0] code;
    logic [1:0]        imm;
  } cmd_t;

  function automatic logic [CNT_W-1:0] slot_count(input logic [CODE_W-1:0] c);
    return (c == 4'd15) ? CNT_W'(13) : CNT_W'(c - 4'd3);
  endfunction

  function automatic logic [6:0] frame_adj(input logic [CODE_W-1:0] c, input logic [1:0] imm);
    logic [6:0] base;
    if (c == 4'd15)     base = 7'd64;
    else if (c >= 4'd12) base = 7'd48;
    else if (c >= 4'd8)  base = 7'd32;
    else                 base = 7'd16;
    return base + {imm, 4'b0000};
  endfunction

  function automatic logic [REG_W-1:0] slot_reg(input logic [CNT_W-1:0] k);
    case (k)
      4'd0:    return 5'd1;
      4'd1:    return 5'd8;
      4'd2:    return 5'd9;
      default: return REG_W'(k) + 5'd15;
    endcase
  endfunction

  function automatic logic is_push(input op_e op);
    return (op == OP_PUSH) || (op == OP_PUSHFP);
  endfunction
endpackage

// File: rtl/stack_seq_decode.sv
module stack_seq_decode
  import stack_seq_pkg::*;
(
  input  logic [15:0] instr_i,
  output cmd_t        cmd_o,
  output logic        legal_o
);
  logic major_ok, func_ok;
  op_e  op;

  always_comb begin
    func_ok = 1'b1;
    op      = OP_PUSH;
    unique case (instr_i[12:8])
      5'b11000: op = OP_PUSH;
      5'b11001: op = OP_PUSHFP;
      5'b11010: op = OP_POP;
      5'b11100: op = OP_POPRETZ;
      5'b11110: op = OP_POPRET;
      default:  func_ok = 1'b0;
    endcase
  end

  assign major_ok = (instr_i[15:13] == 3'b101) && (instr_i[1:0] == 2'b10);
  assign legal_o  = major_ok && func_ok && (instr_i[7:4] >= 4'd4);
  assign cmd_o    = '{op: op, code: instr_i[7:4], imm: instr_i[3:2]};
endmodule

// File: rtl/stack_seq_agu.sv
module stack_seq_agu
  import stack_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cmd_t             cmd_i,
  input  logic [XLEN-1:0]  sp_base_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [XLEN-1:0]  addr_o,
  output logic [REG_W-1:0] reg_o,
  output logic [XLEN-1:0]  sp_next_o
);
  logic [XLEN-1:0] adj, off, top;

  assign adj       = XLEN'(frame_adj(cmd_i.code, cmd_i.imm));
  assign off       = (XLEN'(cnt_i) << 2) + XLEN'(4);
  // frame top: incoming sp for push, restored sp for pop
  assign top       = is_push(cmd_i.op) ? sp_base_i : sp_base_i + adj;
  assign addr_o    = top - off;
  assign reg_o     = slot_reg(cnt_i);
  assign sp_next_o = is_push(cmd_i.op) ? sp_base_i - adj : sp_base_i + adj;
endmodule

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_valid_i,
  input  cmd_t             cmd_i,
  input  logic             legal_i,
  input  logic [XLEN-1:0]  sp_i,
  input  logic [XLEN-1:0]  addr_i,
  input  logic [REG_W-1:0] reg_i,
  input  logic [XLEN-1:0]  sp_next_i,
  output cmd_t             cmd_q_o,
  output logic [XLEN-1:0]  sp_q_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             illegal_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [REG_W-1:0] mem_reg_o,
  output logic             rf_we_o,
  output logic [REG_W-1:0] rf_waddr_o,
  output logic [XLEN-1:0]  rf_wdata_o,
  output logic             jump_o
);
  typedef enum logic [2:0] {S_IDLE, S_XFER, S_FPW, S_A0W, S_FIN, S_ERR} st_e;
  st_e              st_q, st_d;
  cmd_t             cmd_q;
  logic [XLEN-1:0]  sp_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last = (cnt_q == slot_count(cmd_q.code) - CNT_W'(1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      S_IDLE: if (instr_valid_i) begin
        st_d  = legal_i ? S_XFER : S_ERR;
        cnt_d = '0;
      end
      S_XFER: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (last) begin
          if (cmd_q.op == OP_PUSHFP)       st_d = S_FPW;
          else if (cmd_q.op == OP_POPRETZ) st_d = S_A0W;
          else                             st_d = S_FIN;
        end
      end
      S_FPW, S_A0W: st_d = S_FIN;
      default:      st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      cmd_q <= '{op: OP_PUSH, code: '0, imm: '0};
      sp_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (st_q == S_IDLE && instr_valid_i) begin
        cmd_q <= cmd_i;
        sp_q  <= sp_i;
      end
    end
  end

  assign cmd_q_o    = cmd_q;
  assign sp_q_o     = sp_q;
  assign cnt_o      = cnt_q;
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = (st_q == S_FIN) || (st_q == S_ERR);
  assign illegal_o  = (st_q == S_ERR);
  assign mem_req_o  = (st_q == S_XFER);
  assign mem_we_o   = mem_req_o && is_push(cmd_q.op);
  assign mem_addr_o = mem_req_o ? addr_i : '0;
  assign mem_reg_o  = mem_req_o ? reg_i : '0;
  assign rf_we_o    = (st_q == S_FPW) || (st_q == S_A0W) || (st_q == S_FIN);
  assign jump_o     = (st_q == S_FIN) &&
                      ((cmd_q.op == OP_POPRET) || (cmd_q.op == OP_POPRETZ));

  always_comb begin
    rf_waddr_o = '0;
    rf_wdata_o = '0;
    unique case (st_q)
      S_FPW:   begin rf_waddr_o = 5'd8;  rf_wdata_o = sp_q;      end
      S_A0W:   begin rf_waddr_o = 5'd10; rf_wdata_o = '0;        end
      S_FIN:   begin rf_waddr_o = 5'd2;  rf_wdata_o = sp_next_i; end
      default: ;
    endcase
  end

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(instr_valid_i));
  assert_illegal_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!mem_req_o && !rf_we_o));
  assert_sp_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && rf_waddr_o == 5'd2) |-> (done_o && !mem_req_o));
  assert_fp_then_sp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && rf_waddr_o == 5'd8) |=> (rf_we_o && rf_waddr_o == 5'd2));
endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
  import stack_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            instr_valid_i,
  input  logic [15:0]     instr_i,
  input  logic [XLEN-1:0] sp_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            illegal_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [4:0]      mem_reg_o,
  output logic            rf_we_o,
  output logic [4:0]      rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            jump_o
);
  cmd_t             dec_cmd, cmd_q;
  logic             dec_legal;
  logic [XLEN-1:0]  sp_q, agu_addr, agu_sp;
  logic [CNT_W-1:0] cnt;
  logic [REG_W-1:0] agu_reg;

  stack_seq_decode i_decode (
    .instr_i (instr_i),
    .cmd_o   (dec_cmd),
    .legal_o (dec_legal)
  );

  stack_seq_agu #(.XLEN(XLEN)) i_agu (
    .cmd_i     (cmd_q),
    .sp_base_i (sp_q),
    .cnt_i     (cnt),
    .addr_o    (agu_addr),
    .reg_o     (agu_reg),
    .sp_next_o (agu_sp)
  );

  stack_seq_ctrl #(.XLEN(XLEN)) i_ctrl (
    .clk_i, .rst_ni, .instr_valid_i,
    .cmd_i      (dec_cmd),
    .legal_i    (dec_legal),
    .sp_i       (sp_i),
    .addr_i     (agu_addr),
    .reg_i      (agu_reg),
    .sp_next_i  (agu_sp),
    .cmd_q_o    (cmd_q),
    .sp_q_o     (sp_q),
    .cnt_o      (cnt),
    .busy_o, .done_o, .illegal_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_reg_o,
    .rf_we_o, .rf_waddr_o, .rf_wdata_o, .jump_o
  );

  assert_addr_stride_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> (mem_addr_o == $past(mem_addr_o) - XLEN'(4)));
  assert_jump_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |-> (done_o && !mem_we_o));
endmodule

// File: tb/test_stack_frame_seq.sv
module test_stack_frame_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] instr = '0;
  logic [31:0] sp = '0;
  logic        busy, done, illegal, mem_req, mem_we, rf_we, jump;
  logic [31:0] mem_addr, rf_wdata;
  logic [4:0]  mem_reg, rf_waddr;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  stack_frame_seq i_stack_frame_seq (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .instr_i(instr), .sp_i(sp),
    .busy_o(busy), .done_o(done), .illegal_o(illegal), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_reg_o(mem_reg), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .jump_o(jump)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int m_count(input int c);
    return (c == 15) ? 13 : c - 3;
  endfunction
  function automatic int m_adj(input int c, input int imm);
    int b;
    b = (c <= 7) ? 16 : (c <= 11) ? 32 : (c <= 14) ? 48 : 64;
    return b + 16 * imm;
  endfunction
  function automatic int m_reg(input int k);
    if (k == 0) return 1;
    if (k == 1) return 8;
    if (k == 2) return 9;
    return 18 + (k - 3);
  endfunction
  // 0 push, 1 pushfp, 2 pop, 3 popretz, 4 popret, -1 reserved
  function automatic int m_op(input logic [4:0] f);
    case (f)
      5'b11000: return 0;
      5'b11001: return 1;
      5'b11010: return 2;
      5'b11100: return 3;
      5'b11110: return 4;
      default:  return -1;
    endcase
  endfunction

  task automatic run_seq(input logic [15:0] w, input logic [31:0] s);
    int op, n, adj, extra, total, code;
    bit ok;
    logic [31:0] exp_sp;
    code = int'(w[7:4]);
    op   = m_op(w[12:8]);
    ok   = (w[15:13] == 3'b101) && (w[1:0] == 2'b10) && (op >= 0) && (code >= 4);
    n     = ok ? m_count(code) : 0;
    adj   = ok ? m_adj(code, int'(w[3:2])) : 0;
    extra = (op == 1 || op == 3) ? 1 : 0;
    total = ok ? n + extra + 1 : 1;
    exp_sp = (op <= 1) ? s - 32'(adj) : s + 32'(adj);
    @(negedge clk);
    instr = w; sp = s; valid = 1'b1;
    for (int c = 0; c < total; c++) begin
      @(negedge clk);
      instr = 16'($urandom); sp = $urandom;  // R10: ignored while busy
      chk("R10", "busy", busy, 1);
      if (!ok) begin
        chk("R9", "done", done, 1);
        chk("R9", "illegal", illegal, 1);
        chk("R9", "req/we", {mem_req, rf_we}, 0);
      end else if (c < n) begin
        chk(op <= 1 ? "R4" : "R5", "req", {mem_req, mem_we, rf_we, done}, {1'b1, op <= 1, 2'b00});
        chk(op <= 1 ? "R4" : "R5", "addr", mem_addr,
            (op <= 1) ? s - 32'(4 * (c + 1)) : s + 32'(adj) - 32'(4 * (c + 1)));
        chk("R2", "reg", 32'(mem_reg), 32'(m_reg(c)));
      end else if (c == n && extra == 1) begin
        chk(op == 1 ? "R7" : "R8", "extra wr", {mem_req, rf_we, done}, 3'b010);
        chk(op == 1 ? "R7" : "R8", "waddr", 32'(rf_waddr), op == 1 ? 8 : 10);
        chk(op == 1 ? "R7" : "R8", "wdata", rf_wdata, op == 1 ? s : 32'd0);
      end else begin
        chk("R6", "final", {mem_req, rf_we, done, illegal}, 4'b0110);
        chk("R6", "waddr", 32'(rf_waddr), 2);
        chk("R3", "sp", rf_wdata, exp_sp);
        chk("R8", "jump", jump, (op >= 3) ? 1 : 0);
      end
      if (c == total - 1) valid = 1'b0;
    end
    @(negedge clk);
    chk("R10", "idle after done", {busy, done, mem_req, rf_we}, 0);
  endtask

  function automatic logic [15:0] mk(input logic [4:0] f, input int code, input int imm);
    return {3'b101, f, 4'(code), 2'(imm), 2'b10};
  endfunction

  initial begin
    logic [4:0] funcs [5];
    funcs = '{5'b11000, 5'b11001, 5'b11010, 5'b11100, 5'b11110};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R10", "reset outputs", {busy, done, illegal, mem_req, rf_we, jump}, 0);
    rst_n = 1'b1;
    // R1 R2 R3: every operation, list code and adjustment field
    for (int f = 0; f < 5; f++)
      for (int c = 4; c < 16; c++)
        for (int i = 0; i < 4; i++)
          run_seq(mk(funcs[f], c, i), 32'h0000_8000 + 32'($urandom_range(0, 255)) * 16);
    // R9: low list codes, reserved ops, wrong major bits
    for (int c = 0; c < 4; c++) run_seq(mk(5'b11000, c, 2), 32'h1000);
    run_seq(mk(5'b11011, 6, 0), 32'h1000);
    run_seq(mk(5'b11111, 6, 0), 32'h1000);
    run_seq(mk(5'b11000, 6, 0) ^ 16'h0001, 32'h1000);
    run_seq(mk(5'b11000, 6, 0) ^ 16'h2000, 32'h1000);
    // constrained random mix
    for (int r = 0; r < 150; r++) begin
      if (r % 3 == 0) run_seq(16'($urandom), $urandom);
      else run_seq(mk(funcs[$urandom_range(0, 4)], $urandom_range(0, 15), $urandom_range(0, 3)),
                   $urandom & 32'hFFFF_FFF0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule